// File: doc/BRIEF.md
# Low-Power SDRAM Bring-Up and Deep Power-Down Sequencer

This block is the controller-side engine that takes a low-power SDRAM from an unpowered or deep-power-down state to a usable one. It drives the clock-enable line and the chip-select, row-strobe, column-strobe, write-enable, bank and address lines of the memory command bus. After reset it holds clock enable high with no-operation commands for a programmable stable period. It then closes every bank with a precharge-all and issues a programmable number of auto-refresh commands. Next it loads the mode register and then the extended mode register, and raises a ready flag once the last register write has settled.

Once ready, the host may ask for deep power-down. The sequencer issues the entry command while lowering clock enable, and holds the device there. Array contents are lost in that state. An exit request therefore raises clock enable and replays the complete bring-up flow, starting with the stable period. All spacings (stable period, precharge time, refresh cycle time, register-write settle time) and the refresh count are parameters in clock cycles. Read and write traffic belongs to another block.

Top module: `lpsdr_init_seq`

## Requirements
- R1: While reset is asserted, `sd_cke` is 0, `init_done` is 0, the command pins {cs_n,ras_n,cas_n,we_n} read 0111 (no-operation), and `sd_ba` and `sd_addr` are zero.
- R2: In the first PAUSE_CYC cycles after reset release, `sd_cke` is 1 and the bus carries no-operation. In the next cycle it carries precharge-all: pins 0010, `sd_addr` bit 10 set, all other address bits 0, bank 0.
- R3: The first auto-refresh (pins 0001, address and bank 0) comes TRP_CYC cycles after the precharge-all. NREF refreshes are issued, each TRC_CYC cycles after the one before, with no-operation on every cycle between commands.
- R4: TRC_CYC cycles after the last refresh, the mode register write appears: pins 0000, bank 00, and `sd_addr` equal to `mr_opcode`.
- R5: TMRD_CYC cycles after the mode register write, the extended register write appears: pins 0000, bank 10 (`sd_ba[1]`=1). It carries `emr_pasr` on address bits 2..0, `emr_tcsr` on bits 4..3 and `emr_drive` on bits 6..5, with every higher address bit 0.
- R6: `init_done` rises exactly TMRD_CYC cycles after the extended register write. While it is 1, `sd_cke` is 1 and the bus carries no-operation.
- R7: A `dpd_req` sampled while `init_done` is 1 produces, on the next cycle, `sd_cke` 0 with pins 0110 and `init_done` 0. Clock enable then stays 0 with no-operation until an exit.
- R8: A `dpd_exit` sampled in deep power-down raises `sd_cke` on the next cycle. The full R2 to R6 sequence then repeats with identical cycle spacing.
- R9: `dpd_req` has no effect unless `init_done` is 1, and `dpd_exit` has no effect outside deep power-down.
- R10: `sd_cke` only falls on a cycle carrying the deep power-down entry command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dpd_req | input | 1 | Request deep power-down entry (acted on only when ready) |
| dpd_exit | input | 1 | Request deep power-down exit (acted on only in deep power-down) |
| mr_opcode | input | ADDR_W | Operating mode word placed on the address bus by the mode register write |
| emr_pasr | input | 3 | Partial-array refresh coverage code for the extended register |
| emr_tcsr | input | 2 | Temperature range code for the extended register |
| emr_drive | input | 2 | Output drive strength code for the extended register |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Memory ready for normal commands |

## Verification
The bring-up flow is run from power-on reset and then from three deep power-down exits. Each run uses new random mode words and extended-register field codes, so a field placed on the wrong address bits, or an opcode latched too early, shows up as a mismatch in one run and not in another. Random pulses on both request inputs are scattered across every phase in which they must be ignored. Any reaction to them breaks the cycle-exact command timeline the bench expects. Variable dwell times in the ready and powered-down states show whether entry and exit depend only on the request and not on how long the sequencer has idled.

// File: rtl/lpsdr_pkg.sv
package lpsdr_pkg;

  typedef enum logic [3:0] {
    ST_OFF, ST_PAUSE, ST_PREA, ST_TRP, ST_REF, ST_TRC,
    ST_MRS, ST_TMRD1, ST_EMRS, ST_TMRD2, ST_READY, ST_DPD_ENT, ST_DPD
  } seq_st_e;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_PREA, CMD_REF, CMD_MRS, CMD_EMRS, CMD_DPD
  } cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] pins_of(cmd_e c);
    case (c)
      CMD_PREA: pins_of = 4'b0010;
      CMD_REF:  pins_of = 4'b0001;
      CMD_MRS,
      CMD_EMRS: pins_of = 4'b0000;
      CMD_DPD:  pins_of = 4'b0110;
      default:  pins_of = 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/lpsdr_wait_timer.sv
module lpsdr_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/lpsdr_ref_tally.sv
module lpsdr_ref_tally #(
  parameter int NREF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic all_done
);
  localparam int RW = $clog2(NREF + 1);
  logic [RW-1:0] tally_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tally_q <= '0;
    else if (clear) tally_q <= '0;
    else if (bump)  tally_q <= tally_q + 1'b1;
  end

  assign all_done = (tally_q == RW'(NREF));
endmodule

// File: rtl/lpsdr_cmd_drive.sv
module lpsdr_cmd_drive
  import lpsdr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_nx,
  input  logic              cke_nx,
  input  logic [ADDR_W-1:0] mr_opcode,
  input  logic [2:0]        emr_pasr,
  input  logic [1:0]        emr_tcsr,
  input  logic [1:0]        emr_drive,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int AP_BIT = 10;

  logic [3:0]        pins_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    pins_d = pins_of(cmd_nx);
    ba_d   = 2'b00;
    addr_d = '0;
    case (cmd_nx)
      CMD_PREA: addr_d[AP_BIT] = 1'b1;
      CMD_MRS:  addr_d = mr_opcode;
      CMD_EMRS: begin
        ba_d   = 2'b10;
        addr_d = ADDR_W'({emr_drive, emr_tcsr, emr_pasr});
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_cke <= 1'b0;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0111;
      sd_ba   <= '0;
      sd_addr <= '0;
    end else begin
      sd_cke <= cke_nx;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= pins_d;
      sd_ba   <= ba_d;
      sd_addr <= addr_d;
    end
  end
endmodule

// File: rtl/lpsdr_init_seq.sv
module lpsdr_init_seq
  import lpsdr_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PAUSE_CYC = 20000,
  parameter int TRP_CYC   = 2,
  parameter int TRC_CYC   = 7,
  parameter int TMRD_CYC  = 2,
  parameter int NREF      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dpd_req,
  input  logic              dpd_exit,
  input  logic [ADDR_W-1:0] mr_opcode,
  input  logic [2:0]        emr_pasr,
  input  logic [1:0]        emr_tcsr,
  input  logic [1:0]        emr_drive,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  localparam int MAX_A = (PAUSE_CYC > TRC_CYC) ? PAUSE_CYC : TRC_CYC;
  localparam int MAX_B = (TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC;
  localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_W + 1);
  localparam logic [CW-1:0] LD_PAUSE = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] LD_TRP   = CW'(TRP_CYC - 2);
  localparam logic [CW-1:0] LD_TRC   = CW'(TRC_CYC - 2);
  localparam logic [CW-1:0] LD_TMRD  = CW'(TMRD_CYC - 2);

  seq_st_e       st_q, st_d;
  logic          t_load, t_exp;
  logic [CW-1:0] t_val;
  logic          r_clr, r_bump, r_done;
  cmd_e          cmd_d;
  logic          cke_d;

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    r_clr  = 1'b0;
    r_bump = 1'b0;
    case (st_q)
      ST_OFF:     begin st_d = ST_PAUSE; t_load = 1'b1; t_val = LD_PAUSE; end
      ST_PAUSE:   if (t_exp) st_d = ST_PREA;
      ST_PREA:    begin st_d = ST_TRP; t_load = 1'b1; t_val = LD_TRP; r_clr = 1'b1; end
      ST_TRP:     if (t_exp) st_d = ST_REF;
      ST_REF:     begin st_d = ST_TRC; t_load = 1'b1; t_val = LD_TRC; r_bump = 1'b1; end
      ST_TRC:     if (t_exp) st_d = r_done ? ST_MRS : ST_REF;
      ST_MRS:     begin st_d = ST_TMRD1; t_load = 1'b1; t_val = LD_TMRD; end
      ST_TMRD1:   if (t_exp) st_d = ST_EMRS;
      ST_EMRS:    begin st_d = ST_TMRD2; t_load = 1'b1; t_val = LD_TMRD; end
      ST_TMRD2:   if (t_exp) st_d = ST_READY;
      ST_READY:   if (dpd_req) st_d = ST_DPD_ENT;
      ST_DPD_ENT: st_d = ST_DPD;
      ST_DPD:     if (dpd_exit) begin st_d = ST_PAUSE; t_load = 1'b1; t_val = LD_PAUSE; end
      default:    st_d = ST_OFF;
    endcase
  end

  // Output encoding looks at the next state so the registered pins line up
  // with the state register cycle for cycle.
  always_comb begin
    case (st_d)
      ST_PREA:    cmd_d = CMD_PREA;
      ST_REF:     cmd_d = CMD_REF;
      ST_MRS:     cmd_d = CMD_MRS;
      ST_EMRS:    cmd_d = CMD_EMRS;
      ST_DPD_ENT: cmd_d = CMD_DPD;
      default:    cmd_d = CMD_NOP;
    endcase
    cke_d = !(st_d inside {ST_OFF, ST_DPD_ENT, ST_DPD});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_OFF;
      init_done <= 1'b0;
    end else begin
      st_q      <= st_d;
      init_done <= (st_d == ST_READY);
    end
  end

  lpsdr_wait_timer #(.CW(CW)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  lpsdr_ref_tally #(.NREF(NREF)) tally_i (
    .clk(clk), .rst_n(rst_n), .clear(r_clr), .bump(r_bump), .all_done(r_done)
  );

  lpsdr_cmd_drive #(.ADDR_W(ADDR_W)) drive_i (
    .clk(clk), .rst_n(rst_n), .cmd_nx(cmd_d), .cke_nx(cke_d),
    .mr_opcode(mr_opcode), .emr_pasr(emr_pasr), .emr_tcsr(emr_tcsr),
    .emr_drive(emr_drive),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );
endmodule

// File: rtl/lpsdr_init_seq_chk.sv
module lpsdr_init_seq_chk #(
  parameter int ADDR_W   = 13,
  parameter int TRP_CYC  = 2,
  parameter int TRC_CYC  = 7,
  parameter int TMRD_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cke,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [1:0]        sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);
  localparam logic [2:0] K_NONE = 3'd0, K_PREA = 3'd1, K_REF = 3'd2,
                         K_MRS = 3'd3, K_EMRS = 3'd4;

  logic [3:0]  pins;
  logic        is_nop, is_prea, is_ref, is_mrs, is_emrs, is_dpd;
  logic [2:0]  last_q;
  logic [15:0] gap_q;

  assign pins    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_nop  = (pins == 4'b0111);
  assign is_prea = sd_cke && (pins == 4'b0010);
  assign is_ref  = sd_cke && (pins == 4'b0001);
  assign is_mrs  = sd_cke && (pins == 4'b0000) && (sd_ba == 2'b00);
  assign is_emrs = sd_cke && (pins == 4'b0000) && (sd_ba == 2'b10);
  assign is_dpd  = (pins == 4'b0110);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= K_NONE;
      gap_q  <= '0;
    end else begin
      if (is_prea)      last_q <= K_PREA;
      else if (is_ref)  last_q <= K_REF;
      else if (is_mrs)  last_q <= K_MRS;
      else if (is_emrs) last_q <= K_EMRS;
      if (is_prea || is_ref || is_mrs || is_emrs) gap_q <= 16'd1;
      else if (gap_q != 16'hFFFF)                 gap_q <= gap_q + 16'd1;
    end
  end

  p_prea_ap_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_prea |-> (sd_addr[10] && sd_ba == 2'b00));

  p_ref_after_prea_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_q == K_PREA) |-> (gap_q == 16'(TRP_CYC)));

  p_ref_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_q == K_REF) |-> (gap_q == 16'(TRC_CYC)));

  p_mrs_after_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (last_q == K_REF && gap_q == 16'(TRC_CYC)));

  p_emrs_after_mrs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_emrs |-> (last_q == K_MRS && gap_q == 16'(TMRD_CYC)));

  p_emrs_high_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_emrs |-> ((sd_addr >> 7) == '0));

  p_ready_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (last_q == K_EMRS && gap_q == 16'(TMRD_CYC)));

  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (sd_cke && is_nop));

  p_cke_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_cke) |-> (is_dpd && !init_done));

  p_cke_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> (is_nop && !init_done));
endmodule

bind lpsdr_init_seq lpsdr_init_seq_chk #(
  .ADDR_W(ADDR_W), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .TMRD_CYC(TMRD_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
);

// File: tb/lpsdr_init_seq_tb_top.sv
module lpsdr_init_seq_tb_top;
  localparam int AW   = 13;
  localparam int P    = 30;
  localparam int TRP  = 3;
  localparam int TRC  = 5;
  localparam int TMRD = 2;
  localparam int NR   = 8;

  localparam int C_NOP = 0, C_PREA = 1, C_REF = 2, C_MRS = 3, C_EMRS = 4, C_DPD = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dpd_req, dpd_exit;
  logic [AW-1:0] mr_opcode;
  logic [2:0]    emr_pasr;
  logic [1:0]    emr_tcsr, emr_drive;
  logic          sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0]    sd_ba;
  logic [AW-1:0] sd_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lpsdr_init_seq #(.ADDR_W(AW), .PAUSE_CYC(P), .TRP_CYC(TRP), .TRC_CYC(TRC),
                   .TMRD_CYC(TMRD), .NREF(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .dpd_req(dpd_req), .dpd_exit(dpd_exit),
    .mr_opcode(mr_opcode), .emr_pasr(emr_pasr), .emr_tcsr(emr_tcsr),
    .emr_drive(emr_drive), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
  );

  function automatic logic [3:0] exp_pins(int code);
    case (code)
      C_PREA:        return 4'b0010;
      C_REF:         return 4'b0001;
      C_MRS, C_EMRS: return 4'b0000;
      C_DPD:         return 4'b0110;
      default:       return 4'b0111;
    endcase
  endfunction

  // {cke, pins[3:0], ready, ba[1:0], addr}
  function automatic logic [31:0] exp_word(logic cke, int code, logic rdy);
    logic [1:0]    ba;
    logic [AW-1:0] ad;
    ba = 2'b00;
    ad = '0;
    if (code == C_PREA) ad[10] = 1'b1;
    if (code == C_MRS)  ad = mr_opcode;
    if (code == C_EMRS) begin
      ba = 2'b10;
      ad = AW'({emr_drive, emr_tcsr, emr_pasr});
    end
    return 32'({cke, exp_pins(code), rdy, ba, ad});
  endfunction

  function automatic logic [31:0] obs_word();
    return 32'({sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done, sd_ba, sd_addr});
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One full bring-up; cycle k=1 is the first cycle after the triggering edge.
  task automatic run_init(bit after_dpd);
    int tp, tm, te, ty;
    mr_opcode = AW'($urandom);
    emr_pasr  = 3'($urandom);
    emr_tcsr  = 2'($urandom);
    emr_drive = 2'($urandom);
    tp = P + 1;
    tm = tp + TRP + (NR - 1) * TRC + TRC;
    te = tm + TMRD;
    ty = te + TMRD;
    for (int k = 1; k <= ty; k++) begin
      int    code;
      string tag;
      @(negedge clk);
      code = C_NOP;
      tag  = after_dpd ? "R8 pause" : "R2 pause";
      if (k == tp) begin code = C_PREA; tag = after_dpd ? "R8 precharge-all" : "R2 precharge-all"; end
      else if (k > tp && k < tm) begin
        tag = "R3 refresh phase";
        if ((k - tp - TRP) >= 0 && ((k - tp - TRP) % TRC) == 0) code = C_REF;
      end
      else if (k >= tm && k < te) begin tag = "R4 mode write"; if (k == tm) code = C_MRS; end
      else if (k >= te && k < ty) begin tag = "R5 ext write"; if (k == te) code = C_EMRS; end
      else if (k == ty) tag = "R6 ready rise";
      chk(tag, obs_word(), exp_word(1'b1, code, k == ty));
      // R9: requests outside their states must leave this timeline untouched
      if (k <= ty - 2) begin
        dpd_req  = 1'($urandom);
        dpd_exit = 1'($urandom);
      end else begin
        dpd_req  = 1'b0;
        dpd_exit = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b0;
    dpd_req = 1'b0;
    dpd_exit = 1'b0;
    mr_opcode = '0;
    emr_pasr = '0;
    emr_tcsr = '0;
    emr_drive = '0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 reset state", obs_word(), 32'({1'b0, 4'b0111, 1'b0, 2'b00, {AW{1'b0}}}));
    end
    rst_n = 1'b1;
    run_init(1'b0);

    for (int round = 0; round < 3; round++) begin
      int dwell;
      dwell = 3 + int'($urandom % 5);
      for (int i = 0; i < dwell; i++) begin
        @(negedge clk);
        chk("R6/R9 ready hold, exit ignored", obs_word(), exp_word(1'b1, C_NOP, 1'b1));
        dpd_exit = 1'($urandom);
      end
      dpd_exit = 1'b0;
      dpd_req  = 1'b1;
      @(negedge clk);
      chk("R7 dpd entry", obs_word(), exp_word(1'b0, C_DPD, 1'b0));
      chk("R10 cke falls with entry", 32'(sd_cke), 32'(0));
      dpd_req = 1'b0;
      dwell = 2 + int'($urandom % 6);
      for (int i = 0; i < dwell; i++) begin
        @(negedge clk);
        chk("R7/R9 dpd hold, req ignored", obs_word(), exp_word(1'b0, C_NOP, 1'b0));
        dpd_req = 1'($urandom);
      end
      dpd_exit = 1'b1;
      run_init(1'b1);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule